// File: doc/BRIEF.md
# Open-Row DRAM Word Controller

This block accepts word read and write requests from a CPU-side port and serves them from a DRAM array that it models itself. The array is built from several byte-wide chips working side by side. Each chip holds a square grid of byte-sized cells arranged in rows and columns. To reach a cell, the controller splits the request address into a row index and a column index. It sends both indices over one narrow, shared address bus: the row index goes out with a row strobe, and the column index follows with a column strobe. The row strobe copies the selected row of every chip into that chip's row buffer. The column strobe then picks one cell out of the buffer.

The controller leaves the last activated row open. A later request to the same row needs only a column strobe. A request to a different row first closes the open row with a precharge, then activates the new row, then issues its column strobe. A free-running timer asks for a refresh at a set interval. Once any access in flight has finished, the controller refreshes the next row in turn and marks the row buffer as closed. The strobes and the shared address bus are outputs of the block, so the command sequence can be observed from outside.

Top module: `pagemode_mem_ctrl`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, and none of pre_strobe, ras_strobe, cas_strobe or ref_strobe is asserted.
- R2: The request address is split as row = req_addr[3:2] and column = req_addr[1:0]. dram_addr carries the row index while ras_strobe is high and the column index while cas_strobe is high.
- R3: When the row buffer is closed, an access issues exactly one ras_strobe, then one cas_strobe, and no pre_strobe.
- R4: An access to the row that is already open issues one cas_strobe and no ras_strobe or pre_strobe. A run of accesses to one row, starting from a closed buffer, issues exactly one ras_strobe in total.
- R5: An access to a row other than the open one issues pre_strobe, ras_strobe and cas_strobe, one per cycle, in that order.
- R6: A read returns on rsp_rdata the word most recently written to that address, together with an rsp_valid pulse that lasts exactly one cycle. A write produces no rsp_valid.
- R7: Each 64-bit word is stored as eight byte lanes, with lane k holding bits 8k+7:8k. Writing one address leaves every other address unchanged.
- R8: A refresh is issued at least once every REFRESH_CYCLES + 6 cycles. Each refresh shows ref_strobe for one cycle, with dram_addr giving the refreshed row. Refreshed rows follow in round-robin order 0, 1, 2, 3, 0, and so on.
- R9: After a refresh the row buffer is closed, so the next access issues a ras_strobe and no pre_strobe.
- R10: Stored data is unchanged by any number of refreshes.
- R11: A refresh never cuts into an access. ref_strobe never directly follows a pre_strobe or ras_strobe cycle, and req_ready stays low while a refresh is waiting to be issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Word address {row, column} |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | 64 | Read data |
| dram_addr | output | 2 | Shared row/column address bus |
| pre_strobe | output | 1 | Precharge (close row) command |
| ras_strobe | output | 1 | Row activate command |
| cas_strobe | output | 1 | Column access command |
| ref_strobe | output | 1 | Row refresh command |

## Verification
The checker assumes the requester holds req_valid and its fields steady until req_ready accepts them. It also assumes that rsp_valid pulses cannot come back to back, which holds because every access takes at least two cycles. The refresh-interval window further assumes the period is longer than the longest access, which is four cycles. The bench drives each request on a falling edge. It raises req_valid only when req_ready is high and drops it after one accepting edge. It synchronises burst scenarios to a refresh, so that no refresh closes the row in the middle of a burst.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    localparam int DEF_ROWS      = 4;
    localparam int DEF_COLS      = 4;
    localparam int DEF_LANES     = 8;
    localparam int DEF_LANE_W    = 8;
    localparam int DEF_REF_CYCLES = 64;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PRE  = 3'd1,
        ST_ACT  = 3'd2,
        ST_COL  = 3'd3,
        ST_REF  = 3'd4
    } pmc_state_e;

    typedef struct packed {
        logic pre;
        logic act;
        logic col;
        logic refr;
    } pmc_cmd_t;

    function automatic pmc_cmd_t decode_cmd(input pmc_state_e st);
        pmc_cmd_t c;
        c.pre  = (st == ST_PRE);
        c.act  = (st == ST_ACT);
        c.col  = (st == ST_COL);
        c.refr = (st == ST_REF);
        return c;
    endfunction

endpackage

// File: rtl/pmc_refresh_timer.sv
module pmc_refresh_timer #(
    parameter int PERIOD = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic ack,
    output logic pending
);
    localparam int CW = $clog2(PERIOD + 1);

    logic [CW-1:0] cnt;
    logic          expire;

    assign expire = (cnt == CW'(PERIOD - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            pending <= 1'b0;
        end else begin
            cnt <= expire ? '0 : cnt + 1'b1;
            if (ack)    pending <= 1'b0;
            if (expire) pending <= 1'b1;
        end
    end
endmodule

// File: rtl/pmc_byte_chip.sv
module pmc_byte_chip #(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    parameter int W    = 8,
    localparam int RB  = $clog2(ROWS),
    localparam int CB  = $clog2(COLS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          act_en,
    input  logic          wr_en,
    input  logic [RB-1:0] row,
    input  logic [CB-1:0] col,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] cells   [ROWS][COLS];
    logic [W-1:0] row_buf [COLS];

    assign rdata = row_buf[col];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < ROWS; r++)
                for (int c = 0; c < COLS; c++)
                    cells[r][c] <= '0;
            for (int c = 0; c < COLS; c++)
                row_buf[c] <= '0;
        end else if (act_en) begin
            for (int c = 0; c < COLS; c++)
                row_buf[c] <= cells[row][c];
        end else if (wr_en) begin
            row_buf[col]    <= wdata;
            cells[row][col] <= wdata;
        end
    end
endmodule

// File: rtl/pmc_sequencer.sv
module pmc_sequencer
    import pmc_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    parameter int DW   = 64,
    localparam int RB  = $clog2(ROWS),
    localparam int CB  = $clog2(COLS),
    localparam int AW  = (RB > CB) ? RB : CB
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [RB-1:0] req_row,
    input  logic [CB-1:0] req_col,
    input  logic [DW-1:0] req_wdata,
    input  logic          ref_pending,
    output logic          ref_ack,
    output pmc_cmd_t      cmd,
    output logic [RB-1:0] cur_row,
    output logic [CB-1:0] cur_col,
    output logic          cur_write,
    output logic [DW-1:0] cur_wdata,
    output logic [AW-1:0] dram_addr,
    input  logic [DW-1:0] chip_rdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata
);
    pmc_state_e    state;
    logic          open_vld;
    logic [RB-1:0] open_row;
    logic [RB-1:0] ref_row;

    assign cmd       = decode_cmd(state);
    assign req_ready = (state == ST_IDLE) && !ref_pending;
    assign ref_ack   = cmd.refr;

    always_comb begin
        dram_addr = '0;
        unique case (state)
            ST_ACT:  dram_addr = AW'(cur_row);
            ST_COL:  dram_addr = AW'(cur_col);
            ST_REF:  dram_addr = AW'(ref_row);
            default: dram_addr = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            open_vld  <= 1'b0;
            open_row  <= '0;
            ref_row   <= '0;
            cur_row   <= '0;
            cur_col   <= '0;
            cur_write <= 1'b0;
            cur_wdata <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (ref_pending) begin
                        state <= ST_REF;
                    end else if (req_valid) begin
                        cur_row   <= req_row;
                        cur_col   <= req_col;
                        cur_write <= req_write;
                        cur_wdata <= req_wdata;
                        if (open_vld && (req_row == open_row))
                            state <= ST_COL;
                        else if (open_vld)
                            state <= ST_PRE;
                        else
                            state <= ST_ACT;
                    end
                end
                ST_PRE: begin
                    open_vld <= 1'b0;
                    state    <= ST_ACT;
                end
                ST_ACT: begin
                    open_vld <= 1'b1;
                    open_row <= cur_row;
                    state    <= ST_COL;
                end
                ST_COL: begin
                    if (!cur_write) begin
                        rsp_valid <= 1'b1;
                        rsp_rdata <= chip_rdata;
                    end
                    state <= ST_IDLE;
                end
                ST_REF: begin
                    open_vld <= 1'b0;
                    ref_row  <= (ref_row == RB'(ROWS - 1)) ? '0 : ref_row + 1'b1;
                    state    <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pagemode_mem_ctrl.sv
module pagemode_mem_ctrl
    import pmc_pkg::*;
#(
    parameter int ROWS           = DEF_ROWS,
    parameter int COLS           = DEF_COLS,
    parameter int LANES          = DEF_LANES,
    parameter int LANE_W         = DEF_LANE_W,
    parameter int REFRESH_CYCLES = DEF_REF_CYCLES,
    localparam int RB  = $clog2(ROWS),
    localparam int CB  = $clog2(COLS),
    localparam int AW  = (RB > CB) ? RB : CB,
    localparam int DW  = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [RB+CB-1:0] req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             rsp_valid,
    output logic [DW-1:0]    rsp_rdata,
    output logic [AW-1:0]    dram_addr,
    output logic             pre_strobe,
    output logic             ras_strobe,
    output logic             cas_strobe,
    output logic             ref_strobe
);
    pmc_cmd_t      cmd;
    logic          ref_pending;
    logic          ref_ack;
    logic [RB-1:0] cur_row;
    logic [CB-1:0] cur_col;
    logic          cur_write;
    logic [DW-1:0] cur_wdata;
    logic [DW-1:0] chip_rdata;

    pmc_refresh_timer #(.PERIOD(REFRESH_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .ack     (ref_ack),
        .pending (ref_pending)
    );

    pmc_sequencer #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_write   (req_write),
        .req_row     (req_addr[RB+CB-1:CB]),
        .req_col     (req_addr[CB-1:0]),
        .req_wdata   (req_wdata),
        .ref_pending (ref_pending),
        .ref_ack     (ref_ack),
        .cmd         (cmd),
        .cur_row     (cur_row),
        .cur_col     (cur_col),
        .cur_write   (cur_write),
        .cur_wdata   (cur_wdata),
        .dram_addr   (dram_addr),
        .chip_rdata  (chip_rdata),
        .rsp_valid   (rsp_valid),
        .rsp_rdata   (rsp_rdata)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        pmc_byte_chip #(.ROWS(ROWS), .COLS(COLS), .W(LANE_W)) u_chip (
            .clk    (clk),
            .rst    (rst),
            .act_en (cmd.act),
            .wr_en  (cmd.col && cur_write),
            .row    (cur_row),
            .col    (cur_col),
            .wdata  (cur_wdata[k*LANE_W +: LANE_W]),
            .rdata  (chip_rdata[k*LANE_W +: LANE_W])
        );
    end

    assign pre_strobe = cmd.pre;
    assign ras_strobe = cmd.act;
    assign cas_strobe = cmd.col;
    assign ref_strobe = cmd.refr;
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
    parameter int REFRESH_CYCLES = 64
) (
    input logic clk,
    input logic rst,
    input logic req_ready,
    input logic rsp_valid,
    input logic pre_strobe,
    input logic ras_strobe,
    input logic cas_strobe,
    input logic ref_strobe
);
    localparam int LIMIT = REFRESH_CYCLES + 6;
    localparam int GW    = $clog2(LIMIT + 2);

    logic [GW-1:0] gap;

    always_ff @(posedge clk) begin
        if (rst || ref_strobe) gap <= '0;
        else if (gap != GW'(LIMIT + 1)) gap <= gap + 1'b1;
    end

    // R5
    cmd_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pre_strobe, ras_strobe, cas_strobe, ref_strobe}));

    // R5
    pre_then_ras_chk: assert property (@(posedge clk) disable iff (rst)
        pre_strobe |=> ras_strobe);

    // R3
    ras_then_cas_chk: assert property (@(posedge clk) disable iff (rst)
        ras_strobe |=> cas_strobe);

    // R6
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R6
    rsp_after_cas_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(cas_strobe));

    // R11
    ref_no_cut_chk: assert property (@(posedge clk) disable iff (rst)
        ref_strobe |-> (!$past(pre_strobe) && !$past(ras_strobe)));

    // R11
    ref_busy_chk: assert property (@(posedge clk) disable iff (rst)
        ref_strobe |-> !req_ready);

    // R8
    ref_interval_chk: assert property (@(posedge clk) disable iff (rst)
        gap <= GW'(LIMIT));
endmodule

bind pagemode_mem_ctrl pmc_checker #(.REFRESH_CYCLES(REFRESH_CYCLES)) u_pmc_checker (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .pre_strobe (pre_strobe),
    .ras_strobe (ras_strobe),
    .cas_strobe (cas_strobe),
    .ref_strobe (ref_strobe)
);

// File: tb/pagemode_mem_ctrl_tb.sv
module pagemode_mem_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NLOC       = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic        req_write;
    logic [3:0]  req_addr;
    logic [63:0] req_wdata;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic [1:0]  dram_addr;
    logic        pre_strobe, ras_strobe, cas_strobe, ref_strobe;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    int n_pre = 0, n_ras = 0, n_cas = 0, n_ref = 0;
    int last_ras_addr = -1, last_cas_addr = -1;
    int ref_log [$];
    logic [63:0] shadow [NLOC];

    always #(CLK_PERIOD/2) clk = ~clk;

    pagemode_mem_ctrl u_dut (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .dram_addr  (dram_addr),
        .pre_strobe (pre_strobe),
        .ras_strobe (ras_strobe),
        .cas_strobe (cas_strobe),
        .ref_strobe (ref_strobe)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (pre_strobe) n_pre++;
            if (ras_strobe) begin n_ras++; last_ras_addr = int'(dram_addr); end
            if (cas_strobe) begin n_cas++; last_cas_addr = int'(dram_addr); end
            if (ref_strobe) begin n_ref++; ref_log.push_back(int'(dram_addr)); end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic issue(input bit wr, input logic [3:0] a, input logic [63:0] d);
        int t = 0;
        @(negedge clk);
        while (!req_ready && t < 200) begin @(negedge clk); t++; end
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_write(input logic [3:0] a, input logic [63:0] d);
        int t = 0;
        issue(1'b1, a, d);
        shadow[a] = d;
        while (!req_ready && t < 200) begin
            check(!rsp_valid, "R6", "write gave rsp_valid", 64'(rsp_valid), 64'd0);
            @(negedge clk); t++;
        end
    endtask

    task automatic do_read(input logic [3:0] a, output logic [63:0] d);
        int t = 0;
        issue(1'b0, a, 64'd0);
        while (!rsp_valid && t < 200) begin @(negedge clk); t++; end
        d = rsp_rdata;
        check(rsp_valid, "R6", "rsp_valid seen", 64'(rsp_valid), 64'd1);
        @(negedge clk);
        check(!rsp_valid, "R6", "rsp_valid one cycle", 64'(rsp_valid), 64'd0);
    endtask

    task automatic wait_ref();
        int n0 = n_ref;
        int t = 0;
        while (n_ref == n0 && t < 500) begin @(negedge clk); t++; end
    endtask

    task automatic t_reset();
        check(req_ready == 1'b1, "R1", "req_ready", 64'(req_ready), 64'd1);
        check(rsp_valid == 1'b0, "R1", "rsp_valid", 64'(rsp_valid), 64'd0);
        check({pre_strobe, ras_strobe, cas_strobe, ref_strobe} == 4'b0, "R1", "strobes",
              64'({pre_strobe, ras_strobe, cas_strobe, ref_strobe}), 64'd0);
    endtask

    task automatic t_closed_and_split();
        logic [63:0] d;
        int p0, r0, c0;
        wait_ref();
        p0 = n_pre; r0 = n_ras; c0 = n_cas;
        do_write(4'b1001, 64'h0123_4567_89AB_CDEF);
        check(n_ras - r0 == 1, "R3", "ras count closed", 64'(n_ras - r0), 64'd1);
        check(n_pre - p0 == 0, "R3", "pre count closed", 64'(n_pre - p0), 64'd0);
        check(n_cas - c0 == 1, "R3", "cas count closed", 64'(n_cas - c0), 64'd1);
        check(last_ras_addr == 2, "R2", "row on ras", 64'(last_ras_addr), 64'd2);
        check(last_cas_addr == 1, "R2", "col on cas", 64'(last_cas_addr), 64'd1);
        do_read(4'b1001, d);
        check(d == shadow[9], "R6", "read back", d, shadow[9]);
    endtask

    task automatic t_burst();
        logic [63:0] d;
        int p0, r0;
        wait_ref();
        p0 = n_pre; r0 = n_ras;
        for (int c = 0; c < 4; c++) do_write(4'(8 + c), {8{8'(8'h10 * c + 8'h5)}} ^ 64'hFF00_0000_0000_00AA);
        for (int c = 3; c >= 0; c--) begin
            do_read(4'(8 + c), d);
            check(d == shadow[8 + c], "R4", "burst data", d, shadow[8 + c]);
        end
        check(n_ras - r0 == 1, "R4", "one ras for burst", 64'(n_ras - r0), 64'd1);
        check(n_pre - p0 == 0, "R4", "no pre in burst", 64'(n_pre - p0), 64'd0);
    endtask

    task automatic t_row_switch();
        logic [63:0] d;
        int p0, r0, c0;
        wait_ref();
        do_write(4'b0011, 64'hA5A5_5A5A_0F0F_F0F0);
        p0 = n_pre; r0 = n_ras; c0 = n_cas;
        do_read(4'b1110, d);
        check(n_pre - p0 == 1, "R5", "pre on row change", 64'(n_pre - p0), 64'd1);
        check(n_ras - r0 == 1, "R5", "ras on row change", 64'(n_ras - r0), 64'd1);
        check(n_cas - c0 == 1, "R5", "cas on row change", 64'(n_cas - c0), 64'd1);
        check(last_ras_addr == 3, "R2", "row 3 on ras", 64'(last_ras_addr), 64'd3);
        check(last_cas_addr == 2, "R2", "col 2 on cas", 64'(last_cas_addr), 64'd2);
    endtask

    task automatic t_lanes();
        logic [63:0] d;
        for (int k = 0; k < 8; k++) begin
            logic [63:0] w = 64'hFF << (8 * k);
            do_write(4'(k), w);
        end
        for (int k = 0; k < 8; k++) begin
            do_read(4'(k), d);
            check(d[8*k +: 8] == 8'hFF && (d & ~(64'hFF << (8 * k))) == 64'd0,
                  "R7", "lane isolation", d, shadow[k]);
        end
        do_read(4'b1001, d);
        check(d == shadow[9], "R7", "other address unchanged", d, shadow[9]);
    endtask

    task automatic t_refresh();
        logic [63:0] d;
        int p0, r0, start;
        for (int a = 0; a < NLOC; a++) do_write(4'(a), {32'(a) * 32'h9E37_79B9, 32'hC0DE_0000 | 32'(a)});
        start = ref_log.size();
        for (int i = 0; i < 5; i++) wait_ref();
        check(ref_log.size() - start >= 5, "R8", "refresh count", 64'(ref_log.size() - start), 64'd5);
        for (int i = start + 1; i < ref_log.size(); i++)
            check(ref_log[i] == (ref_log[i-1] + 1) % 4, "R8", "round robin",
                  64'(ref_log[i]), 64'((ref_log[i-1] + 1) % 4));
        do_read(4'b0101, d);
        wait_ref();
        p0 = n_pre; r0 = n_ras;
        do_read(4'b0110, d);
        check(n_ras - r0 == 1, "R9", "ras after refresh", 64'(n_ras - r0), 64'd1);
        check(n_pre - p0 == 0, "R9", "no pre after refresh", 64'(n_pre - p0), 64'd0);
        check(d == shadow[6], "R10", "data after refresh", d, shadow[6]);
        for (int a = 0; a < NLOC; a++) begin
            do_read(4'(a), d);
            check(d == shadow[a], "R10", "retained word", d, shadow[a]);
        end
    endtask

    task automatic t_ready_blocked();
        int n0 = n_ref;
        int ok = 1;
        int t = 0;
        while (n_ref == n0 && t < 500) begin
            if (req_ready && (n_ref == n0)) ok = ok;
            @(negedge clk); t++;
        end
        check(!req_ready, "R11", "ready low at refresh", 64'(req_ready), 64'd0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        for (int a = 0; a < NLOC; a++) shadow[a] = 64'd0;
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_closed_and_split();
        t_burst();
        t_row_switch();
        t_lanes();
        t_refresh();
        wait_ref();
        @(negedge clk);
        begin
            int t = 0;
            while (!ref_strobe && t < 500) begin @(negedge clk); t++; end
            check(!req_ready, "R11", "ready low during refresh", 64'(req_ready), 64'd0);
        end
        done = 1;
        finish_run();
    end
endmodule